// File: doc/BRIEF.md
# Floating-Point NaN-Boxing Unit

This unit sits between a 64-bit floating-point register file and the execution units of a core. The core supports half and single precision values, and it keeps them inside 64-bit registers. A narrower value is valid only when every bit above its width is 1. When such a value is viewed at any wider precision, it reads as a negative quiet NaN.

On the read side, the unit receives up to `NUM_SRC` register values together with a precision code and a transfer flag. For a compute operation, it checks each narrower operand. A correctly boxed operand passes its low bits to the compute unit. A wrongly boxed operand is replaced by the canonical NaN of that precision. For a transfer operation (a store, or a move to an integer register), the unit passes the low bits through without the check. On the write side, the unit forces all upper bits of a narrower result to 1 before writeback. This applies both to compute results and to transfers into the register file (a load, or a move from an integer register). Double-precision values pass through both paths untouched.

Both paths have one register stage. Each path has its own valid strobe. The read path also reports one boxing status bit per source operand.

Top module: `fpbox_unit`

## Requirements
- R1: After reset, `op_valid`, `wb_valid`, `op_data`, `op_box_ok` and `wb_data` are all zero.
- R2: When a write is presented with precision code 2'b00 (single), `wb_data` one cycle later carries the low 32 input bits unchanged, with bits 63:32 all 1. With code 2'b10 (half), it carries the low 16 input bits, with bits 63:16 all 1.
- R3: When a write is presented with code 2'b01 (double), `wb_data` one cycle later equals the input exactly, including NaN payloads.
- R4: For a single-precision compute read, `op_box_ok` is 1 exactly when bits 63:32 are all 1. The operand's low 32 bits are then the register's low 32 bits. Otherwise they are 0x7FC00000.
- R5: For a half-precision compute read, `op_box_ok` is 1 exactly when bits 63:16 are all 1. The operand's low 16 bits are then the register's low 16 bits. Otherwise they are 0x7E00.
- R6: For a narrower transfer read (`rd_xfer`=1), the operand carries the register's low n bits whatever the upper bits hold. `op_box_ok` still reports the boxing check.
- R7: For a double read, whether compute or transfer, the operand equals all 64 register bits and `op_box_ok` is 1.
- R8: For a narrower read, the operand bits above the selected width are 0.
- R9: Each source operand is checked and replaced independently of the other sources.
- R10: Precision code 2'b11 behaves exactly like double on both paths.
- R11: `op_valid` and `wb_valid` follow `rd_valid` and `wr_valid` with one cycle of delay. While a strobe is low, the data and status outputs of that path keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read request strobe |
| rd_prec | input | 2 | Read precision: 00 single, 01 double, 10 half, 11 as double |
| rd_xfer | input | 1 | 1 = transfer out (store/move), 0 = compute |
| rd_val | input | NUM_SRC*64 | Register values, source k at bits 64k+63:64k |
| op_valid | output | 1 | Operands valid |
| op_data | output | NUM_SRC*64 | Operands delivered to execution, same packing |
| op_box_ok | output | NUM_SRC | Per-source boxing status |
| wr_valid | input | 1 | Write request strobe |
| wr_prec | input | 2 | Write precision, same encoding as read |
| wr_data | input | 64 | Result or incoming transfer value |
| wb_valid | output | 1 | Writeback value valid |
| wb_data | output | 64 | Boxed writeback value |

## Verification
Every result of this unit is due exactly one rising edge after the inputs that cause it are sampled. This holds for the read operands, the status bits and the boxed writeback. The bench changes inputs on the falling edge and lets one rising edge pass. It compares the outputs on the following falling edge, so each comparison sits half a period away from the edge that updates the outputs. The hold tests drop the strobes for one cycle with altered inputs, then compare on that same falling-edge schedule.

// File: rtl/fpbox_pkg.sv
package fpbox_pkg;
    localparam int FLEN   = 64;
    localparam int SGL_W  = 32;
    localparam int HALF_W = 16;

    typedef enum logic [1:0] {
        PREC_SGL  = 2'b00,
        PREC_DBL  = 2'b01,
        PREC_HALF = 2'b10,
        PREC_RSVD = 2'b11
    } prec_e;

    localparam logic [SGL_W-1:0]  CNAN_SGL  = 32'h7FC0_0000;
    localparam logic [HALF_W-1:0] CNAN_HALF = 16'h7E00;
endpackage

// File: rtl/fpbox_unbox.sv
module fpbox_unbox
    import fpbox_pkg::*;
(
    input  logic [FLEN-1:0] reg_val,
    input  prec_e           prec,
    input  logic            xfer,
    output logic [FLEN-1:0] operand,
    output logic            box_ok
);
    localparam int SGL_PAD  = FLEN - SGL_W;
    localparam int HALF_PAD = FLEN - HALF_W;

    always_comb begin
        unique case (prec)
            PREC_SGL: begin
                box_ok  = &reg_val[FLEN-1:SGL_W];
                operand = {{SGL_PAD{1'b0}},
                           (box_ok || xfer) ? reg_val[SGL_W-1:0] : CNAN_SGL};
            end
            PREC_HALF: begin
                box_ok  = &reg_val[FLEN-1:HALF_W];
                operand = {{HALF_PAD{1'b0}},
                           (box_ok || xfer) ? reg_val[HALF_W-1:0] : CNAN_HALF};
            end
            default: begin
                box_ok  = 1'b1;
                operand = reg_val;
            end
        endcase
    end
endmodule

// File: rtl/fpbox_box.sv
module fpbox_box
    import fpbox_pkg::*;
(
    input  logic [FLEN-1:0] data_in,
    input  prec_e           prec,
    output logic [FLEN-1:0] boxed
);
    localparam int SGL_PAD  = FLEN - SGL_W;
    localparam int HALF_PAD = FLEN - HALF_W;

    always_comb begin
        unique case (prec)
            PREC_SGL:  boxed = {{SGL_PAD{1'b1}},  data_in[SGL_W-1:0]};
            PREC_HALF: boxed = {{HALF_PAD{1'b1}}, data_in[HALF_W-1:0]};
            default:   boxed = data_in;
        endcase
    end
endmodule

// File: rtl/fpbox_unit.sv
module fpbox_unit
    import fpbox_pkg::*;
#(
    parameter int NUM_SRC = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_valid,
    input  logic [1:0]              rd_prec,
    input  logic                    rd_xfer,
    input  logic [NUM_SRC*FLEN-1:0] rd_val,
    output logic                    op_valid,
    output logic [NUM_SRC*FLEN-1:0] op_data,
    output logic [NUM_SRC-1:0]      op_box_ok,
    input  logic                    wr_valid,
    input  logic [1:0]              wr_prec,
    input  logic [FLEN-1:0]         wr_data,
    output logic                    wb_valid,
    output logic [FLEN-1:0]         wb_data
);
    localparam int VEC_W = NUM_SRC * FLEN;

    prec_e            rd_prec_e;
    prec_e            wr_prec_e;
    logic [VEC_W-1:0] op_next;
    logic [NUM_SRC-1:0] ok_next;
    logic [FLEN-1:0]  wb_next;

    assign rd_prec_e = prec_e'(rd_prec);
    assign wr_prec_e = prec_e'(wr_prec);

    // Read side: one checker per source operand
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        fpbox_unbox u_unbox (
            .reg_val (rd_val[g*FLEN +: FLEN]),
            .prec    (rd_prec_e),
            .xfer    (rd_xfer),
            .operand (op_next[g*FLEN +: FLEN]),
            .box_ok  (ok_next[g])
        );

        assert_sgl_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
            op_valid && $past(rd_prec) == 2'b00 |->
            op_box_ok[g] == (&$past(rd_val[g*FLEN+SGL_W +: SGL_W])));

        assert_sgl_canon_R4: assert property (@(posedge clk) disable iff (!rst_n)
            op_valid && $past(rd_prec) == 2'b00 && !$past(rd_xfer) &&
            !(&$past(rd_val[g*FLEN+SGL_W +: SGL_W])) |->
            op_data[g*FLEN +: SGL_W] == CNAN_SGL);

        assert_half_canon_R5: assert property (@(posedge clk) disable iff (!rst_n)
            op_valid && $past(rd_prec) == 2'b10 && !$past(rd_xfer) &&
            !(&$past(rd_val[g*FLEN+HALF_W +: FLEN-HALF_W])) |->
            op_data[g*FLEN +: HALF_W] == CNAN_HALF);

        assert_xfer_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
            op_valid && $past(rd_xfer) && $past(rd_prec) == 2'b00 |->
            op_data[g*FLEN +: FLEN] == {32'h0, $past(rd_val[g*FLEN +: SGL_W])});

        assert_dbl_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
            op_valid && $past(rd_prec) == 2'b01 |->
            op_data[g*FLEN +: FLEN] == $past(rd_val[g*FLEN +: FLEN]) && op_box_ok[g]);
    end

    // Write side: boxing shared by compute results and incoming transfers
    fpbox_box u_box (
        .data_in (wr_data),
        .prec    (wr_prec_e),
        .boxed   (wb_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid  <= 1'b0;
            op_data   <= '0;
            op_box_ok <= '0;
        end else begin
            op_valid <= rd_valid;
            if (rd_valid) begin
                op_data   <= op_next;
                op_box_ok <= ok_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_data  <= '0;
        end else begin
            wb_valid <= wr_valid;
            if (wr_valid) wb_data <= wb_next;
        end
    end

    assert_wb_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && $past(wr_prec) == 2'b00 |->
        &wb_data[FLEN-1:SGL_W] && wb_data[SGL_W-1:0] == $past(wr_data[SGL_W-1:0]));

    assert_wb_dbl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && $past(wr_prec) == 2'b01 |-> wb_data == $past(wr_data));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_valid) && $past(rst_n) |-> $stable(wb_data));
endmodule

// File: tb/sim_fpbox_unit.sv
module sim_fpbox_unit;
    localparam int NS = 3;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           rd_valid;
    logic [1:0]     rd_prec;
    logic           rd_xfer;
    logic [NS*64-1:0] rd_val;
    logic           op_valid;
    logic [NS*64-1:0] op_data;
    logic [NS-1:0]  op_box_ok;
    logic           wr_valid;
    logic [1:0]     wr_prec;
    logic [63:0]    wr_data;
    logic           wb_valid;
    logic [63:0]    wb_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    fpbox_unit #(.NUM_SRC(NS)) u0 (
        .clk, .rst_n, .rd_valid, .rd_prec, .rd_xfer, .rd_val,
        .op_valid, .op_data, .op_box_ok,
        .wr_valid, .wr_prec, .wr_data, .wb_valid, .wb_data
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_one(input logic [1:0] p, input logic x, input logic [63:0] v);
        @(negedge clk);
        rd_valid = 1'b1; rd_prec = p; rd_xfer = x;
        rd_val = {v, v, v};
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic wr_one(input logic [1:0] p, input logic [63:0] v);
        @(negedge clk);
        wr_valid = 1'b1; wr_prec = p; wr_data = v;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 op_valid", 64'(op_valid), 64'h0);
        chk("R1 wb_valid", 64'(wb_valid), 64'h0);
        chk("R1 op_data", op_data[63:0], 64'h0);
        chk("R1 op_box_ok", 64'(op_box_ok), 64'h0);
        chk("R1 wb_data", wb_data, 64'h0);
    endtask

    task automatic t_write;
        wr_one(2'b00, 64'h0000_0000_4049_0FDB);
        chk("R2 wb single", wb_data, 64'hFFFF_FFFF_4049_0FDB);
        chk("R11 wb_valid", 64'(wb_valid), 64'h1);
        wr_one(2'b00, 64'hABCD_0123_1234_5678);
        chk("R2 wb single junk", wb_data, 64'hFFFF_FFFF_1234_5678);
        wr_one(2'b10, 64'h0000_5555_0000_3C00);
        chk("R2 wb half", wb_data, 64'hFFFF_FFFF_FFFF_3C00);
        wr_one(2'b01, 64'h7FF0_0000_0000_1234);
        chk("R3 wb double payload", wb_data, 64'h7FF0_0000_0000_1234);
        wr_one(2'b11, 64'h0000_0000_0000_0042);
        chk("R10 wb rsvd", wb_data, 64'h0000_0000_0000_0042);
    endtask

    task automatic t_single;
        rd_one(2'b00, 1'b0, 64'hFFFF_FFFF_3F80_0000);
        chk("R4 sgl good", op_data[63:0], 64'h0000_0000_3F80_0000);
        chk("R4 sgl good ok", 64'(op_box_ok[0]), 64'h1);
        chk("R11 op_valid", 64'(op_valid), 64'h1);
        rd_one(2'b00, 1'b0, 64'hFFFF_FFFE_3F80_0000);
        chk("R4 sgl bad", op_data[63:0], 64'h0000_0000_7FC0_0000);
        chk("R4 sgl bad ok", 64'(op_box_ok[0]), 64'h0);
        rd_one(2'b00, 1'b0, 64'h0000_0000_3F80_0000);
        chk("R8 sgl zero upper", op_data[63:0], 64'h0000_0000_7FC0_0000);
    endtask

    task automatic t_half;
        rd_one(2'b10, 1'b0, 64'hFFFF_FFFF_FFFF_3C00);
        chk("R5 half good", op_data[63:0], 64'h0000_0000_0000_3C00);
        chk("R5 half good ok", 64'(op_box_ok[0]), 64'h1);
        rd_one(2'b10, 1'b0, 64'hFFFF_FFFF_FFFE_3C00);
        chk("R5 half bad", op_data[63:0], 64'h0000_0000_0000_7E00);
        chk("R5 half bad ok", 64'(op_box_ok[0]), 64'h0);
    endtask

    task automatic t_xfer;
        rd_one(2'b00, 1'b1, 64'h1234_5678_DEAD_BEEF);
        chk("R6 xfer sgl", op_data[63:0], 64'h0000_0000_DEAD_BEEF);
        chk("R6 xfer sgl ok", 64'(op_box_ok[0]), 64'h0);
        rd_one(2'b10, 1'b1, 64'h0000_0000_0000_ABCD);
        chk("R6 xfer half", op_data[63:0], 64'h0000_0000_0000_ABCD);
    endtask

    task automatic t_double;
        rd_one(2'b01, 1'b0, 64'h7FF0_0000_0000_0001);
        chk("R7 dbl compute", op_data[63:0], 64'h7FF0_0000_0000_0001);
        chk("R7 dbl ok", 64'(op_box_ok[0]), 64'h1);
        rd_one(2'b01, 1'b1, 64'h0123_4567_89AB_CDEF);
        chk("R7 dbl xfer", op_data[63:0], 64'h0123_4567_89AB_CDEF);
        rd_one(2'b11, 1'b0, 64'h0000_0001_0000_0002);
        chk("R10 rd rsvd", op_data[63:0], 64'h0000_0001_0000_0002);
    endtask

    task automatic t_indep;
        @(negedge clk);
        rd_valid = 1'b1; rd_prec = 2'b00; rd_xfer = 1'b0;
        rd_val = {64'hFFFF_FFFF_4000_0000, 64'h0000_FFFF_4000_0000, 64'hFFFF_FFFF_3F00_0000};
        @(negedge clk);
        rd_valid = 1'b0;
        chk("R9 src0", op_data[63:0],    64'h0000_0000_3F00_0000);
        chk("R9 src1", op_data[127:64],  64'h0000_0000_7FC0_0000);
        chk("R9 src2", op_data[191:128], 64'h0000_0000_4000_0000);
        chk("R9 ok", 64'(op_box_ok), 64'h5);
    endtask

    task automatic t_hold;
        logic [NS*64-1:0] prev_op = op_data;
        logic [NS-1:0]    prev_ok = op_box_ok;
        logic [63:0]      prev_wb = wb_data;
        @(negedge clk);
        rd_valid = 1'b0; rd_prec = 2'b01; rd_val = '1;
        wr_valid = 1'b0; wr_prec = 2'b01; wr_data = 64'h5A5A_5A5A_5A5A_5A5A;
        @(negedge clk);
        chk("R11 op_valid low", 64'(op_valid), 64'h0);
        chk("R11 wb_valid low", 64'(wb_valid), 64'h0);
        chk("R11 op hold", op_data[63:0], prev_op[63:0]);
        chk("R11 ok hold", 64'(op_box_ok), 64'(prev_ok));
        chk("R11 wb hold", wb_data, prev_wb);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rd_valid = 1'b0; rd_prec = 2'b00; rd_xfer = 1'b0; rd_val = '0;
        wr_valid = 1'b0; wr_prec = 2'b00; wr_data = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_write();
        t_single();
        t_half();
        t_xfer();
        t_double();
        t_indep();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule